// File: doc/BRIEF.md
# Cascaded Interrupt Cause and Mask Controller

This block collects 96 level-sensitive interrupt sources arranged as three 32-bit groups: a main low group, a main high group and a group of general-purpose pins. The main groups are sampled into cause registers every cycle. Pin sources are captured into a sticky cause register, and software clears it by writing zero to the bits it wants cleared. Each group has its own CPU mask. The pin group does not reach the CPU directly. It cascades into four summary bits of the main high cause, and each summary bit stands for eight masked pin causes.

Software works through a 32-bit register port that has two windows: the main window and the pin window. A select-cause register in the main window returns whichever masked main half needs service, with a flag bit that tells the two halves apart. One CPU interrupt line goes high for any unmasked main cause. The block also presents the encoded number of the source that software would service next. That number is formed the same way a handler walks the registers: the low half first, then the high half, and through the summary bits into the pin group, picking the highest-numbered pending bit at each step.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset every cause and mask register reads zero, `irq_out` is low and `vec_valid` is low.
- R2: The main low and main high cause registers sample their source inputs on each clock edge and follow the level of those inputs. Main high source bits 24..27 are ignored and are never stored.
- R3: A main-window write to main low cause (0x04) or main high cause (0x0C) clears the bits written as 0 for that cycle. A source that is still asserted sets its bit again on the following edge.
- R4: A pin cause bit (pin window 0x08) sets while its source is high and stays set after the source drops. A pin-window write to 0x08 clears each bit written as 0 and leaves each bit written as 1 unchanged. Sources are not captured on the cycle of that write.
- R5: The masks read back what was written. Main low mask is at main 0x14, main high mask at main 0x1C, and pin mask at pin 0x0C. All masks reset to zero.
- R6: Bit 24+k of the main high cause (k = 0..3) reads as the OR of masked pin cause bits 8k..8k+7. It does not depend on the main high mask.
- R7: Main 0x24 (select-cause) returns the masked low cause when that value is nonzero. Otherwise it returns the masked high cause with bit 30 set.
- R8: `irq_out` is high exactly when some main low or main high cause bit is set along with its mask bit. Pin causes reach it only through the summary bits.
- R9: `vec_id` gives the group in bits 6:5 (0 low, 1 high, 2 pins) and the highest-numbered pending masked bit of that group in bits 4:0.
- R10: The vector picks the low group if any masked low bit is pending. Otherwise it picks the pin group if a masked summary bit is set. Otherwise it picks the high group. `vec_valid` is low when nothing is selected.
- R11: Reads of unmapped offsets in either window return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lo | input | 32 | Main low group sources (level) |
| src_hi | input | 32 | Main high group sources (bits 24..27 unused) |
| src_pin | input | 32 | Pin group sources (level) |
| bus_win | input | 1 | Register window: 0 main, 1 pin |
| bus_addr | input | 8 | Byte offset within the window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_out | output | 1 | CPU interrupt request |
| vec_valid | output | 1 | A source number is presented on vec_id |
| vec_id | output | 7 | Encoded number of the source to service next |

## Verification
A corrupted pin cause bit can be seen in two places one cycle after the fault. It shows in the pin cause readback. Once its mask bit is set, it also shows in the summary nibble of the main high cause, in the select-cause word and on `vec_id`. If a mask register holds the wrong value, `irq_out` goes wrong in the same cycle, and so do the select-cause flag and the group field of the vector. A main cause that has stopped following its input shows up within one edge of the input changing. The directed scenarios therefore read each register straight after the edge that should change it, and compare the vector against a priority walk computed separately in the bench.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int WORD_W    = 32;
  localparam int GRP_W     = 2;
  localparam int BIT_W     = 5;
  localparam int SRC_ID_W  = GRP_W + BIT_W;
  localparam int ADDR_W    = 8;

  // main window offsets
  localparam logic [ADDR_W-1:0] OFF_CAUSE_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CAUSE_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SELECT   = 8'h24;
  // pin window offsets
  localparam logic [ADDR_W-1:0] OFF_PIN_CAUSE = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_PIN_MASK  = 8'h0C;

  typedef enum logic [GRP_W-1:0] {
    GRP_LOW  = 2'd0,
    GRP_HIGH = 2'd1,
    GRP_PIN  = 2'd2
  } grp_e;

  // index of the highest set bit (0 when the word is empty)
  function automatic logic [BIT_W-1:0] top_bit(input logic [WORD_W-1:0] v);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (v[i]) r = BIT_W'(i);
    end
    return r;
  endfunction

  // OR-reduce each slice of SLICE_W bits into one bit per slice
  function automatic logic [3:0] fold_slices(input logic [WORD_W-1:0] v);
    logic [3:0] r;
    for (int s = 0; s < 4; s++) begin
      r[s] = |v[s*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/icc_main_group.sv
module icc_main_group #(
  parameter int W       = 32,
  parameter int HOLE_LSB = 0,
  parameter int HOLE_W   = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         cause_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] keep;
  logic [W-1:0] cause_d;

  // bits reserved for the cascade are never stored from the inputs
  generate
    if (HOLE_W > 0) begin : g_hole
      always_comb begin
        for (int i = 0; i < W; i++) begin
          keep[i] = !((i >= HOLE_LSB) && (i < HOLE_LSB + HOLE_W));
        end
      end
    end else begin : g_nohole
      assign keep = '1;
    end
  endgenerate

  always_comb begin
    cause_d = src & keep;
    if (cause_we) cause_d = cause_d & wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/icc_pin_group.sv
module icc_pin_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         cause_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend
);
  logic [W-1:0] cause_d;

  always_comb begin
    if (cause_we) cause_d = cause_q & wdata;
    else          cause_d = cause_q | src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pend = cause_q & mask_q;
endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter
  import icc_pkg::*;
#(
  parameter int SEL_FLAG  = 30,
  parameter int SUM_LSB   = 24,
  parameter int SUM_W     = 4
) (
  input  logic [WORD_W-1:0]   pend_lo,
  input  logic [WORD_W-1:0]   pend_hi,
  input  logic [WORD_W-1:0]   pend_pin,
  output logic [WORD_W-1:0]   sel_word,
  output logic                sel_is_high,
  output logic                vec_valid,
  output logic [SRC_ID_W-1:0] vec_id
);
  logic lo_any, hi_any, sum_any, pin_any;
  grp_e grp;

  assign lo_any  = |pend_lo;
  assign hi_any  = |pend_hi;
  assign sum_any = |pend_hi[SUM_LSB +: SUM_W];
  assign pin_any = |pend_pin;

  always_comb begin
    sel_is_high = !lo_any;
    sel_word    = pend_lo;
    if (!lo_any) begin
      sel_word = pend_hi;
      sel_word[SEL_FLAG] = 1'b1;
    end
  end

  always_comb begin
    vec_valid = 1'b0;
    grp       = GRP_LOW;
    vec_id    = '0;
    if (lo_any) begin
      vec_valid = 1'b1;
      grp       = GRP_LOW;
      vec_id    = {grp, top_bit(pend_lo)};
    end else if (sum_any) begin
      vec_valid = pin_any;
      grp       = GRP_PIN;
      vec_id    = {grp, top_bit(pend_pin)};
    end else if (hi_any) begin
      vec_valid = 1'b1;
      grp       = GRP_HIGH;
      vec_id    = {grp, top_bit(pend_hi)};
    end
  end
endmodule

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl
  import icc_pkg::*;
#(
  parameter int SUM_LSB  = 24,
  parameter int SUM_W    = 4,
  parameter int SEL_FLAG = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   src_lo,
  input  logic [WORD_W-1:0]   src_hi,
  input  logic [WORD_W-1:0]   src_pin,
  input  logic                bus_win,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                irq_out,
  output logic                vec_valid,
  output logic [SRC_ID_W-1:0] vec_id
);
  localparam int SLICE_W = WORD_W / SUM_W;

  // named strobes
  logic main_sel, pin_sel;
  logic lo_cause_we, hi_cause_we, lo_mask_we, hi_mask_we;
  logic pin_cause_we, pin_mask_we;

  assign main_sel     = !bus_win;
  assign pin_sel      = bus_win;
  assign lo_cause_we  = bus_we && main_sel && (bus_addr == OFF_CAUSE_LO);
  assign hi_cause_we  = bus_we && main_sel && (bus_addr == OFF_CAUSE_HI);
  assign lo_mask_we   = bus_we && main_sel && (bus_addr == OFF_MASK_LO);
  assign hi_mask_we   = bus_we && main_sel && (bus_addr == OFF_MASK_HI);
  assign pin_cause_we = bus_we && pin_sel  && (bus_addr == OFF_PIN_CAUSE);
  assign pin_mask_we  = bus_we && pin_sel  && (bus_addr == OFF_PIN_MASK);

  logic [WORD_W-1:0] lo_cause, lo_mask, hi_cause, hi_mask;
  logic [WORD_W-1:0] pin_cause, pin_mask, pend_pin;

  icc_main_group #(.W(WORD_W), .HOLE_LSB(0), .HOLE_W(0)) u_lo (
    .clk(clk), .rst_n(rst_n), .src(src_lo),
    .cause_we(lo_cause_we), .mask_we(lo_mask_we), .wdata(bus_wdata),
    .cause_q(lo_cause), .mask_q(lo_mask)
  );

  icc_main_group #(.W(WORD_W), .HOLE_LSB(SUM_LSB), .HOLE_W(SUM_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .src(src_hi),
    .cause_we(hi_cause_we), .mask_we(hi_mask_we), .wdata(bus_wdata),
    .cause_q(hi_cause), .mask_q(hi_mask)
  );

  icc_pin_group #(.W(WORD_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .src(src_pin),
    .cause_we(pin_cause_we), .mask_we(pin_mask_we), .wdata(bus_wdata),
    .cause_q(pin_cause), .mask_q(pin_mask), .pend(pend_pin)
  );

  // cascade summary: one bit per slice of masked pin causes
  logic [SUM_W-1:0] pin_summary;
  generate
    for (genvar s = 0; s < SUM_W; s++) begin : g_sum
      assign pin_summary[s] = |pend_pin[s*SLICE_W +: SLICE_W];
    end
  endgenerate

  logic [WORD_W-1:0] hi_cause_view, pend_lo, pend_hi;
  always_comb begin
    hi_cause_view = hi_cause;
    hi_cause_view[SUM_LSB +: SUM_W] = pin_summary;
  end
  assign pend_lo = lo_cause & lo_mask;
  assign pend_hi = hi_cause_view & hi_mask;

  logic [WORD_W-1:0] sel_word;
  logic              sel_is_high;

  icc_arbiter #(.SEL_FLAG(SEL_FLAG), .SUM_LSB(SUM_LSB), .SUM_W(SUM_W)) u_arb (
    .pend_lo(pend_lo), .pend_hi(pend_hi), .pend_pin(pend_pin),
    .sel_word(sel_word), .sel_is_high(sel_is_high),
    .vec_valid(vec_valid), .vec_id(vec_id)
  );

  assign irq_out = |pend_lo || |pend_hi;

  always_comb begin
    bus_rdata = '0;
    if (main_sel) begin
      case (bus_addr)
        OFF_CAUSE_LO: bus_rdata = lo_cause;
        OFF_CAUSE_HI: bus_rdata = hi_cause_view;
        OFF_MASK_LO:  bus_rdata = lo_mask;
        OFF_MASK_HI:  bus_rdata = hi_mask;
        OFF_SELECT:   bus_rdata = sel_word;
        default:      bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        OFF_PIN_CAUSE: bus_rdata = pin_cause;
        OFF_PIN_MASK:  bus_rdata = pin_mask;
        default:       bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/icc_checker.sv
module icc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_out,
  input logic        vec_valid,
  input logic [6:0]  vec_id,
  input logic        pin_cause_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] pin_cause,
  input logic [31:0] pin_mask,
  input logic [31:0] hi_cause_view,
  input logic [31:0] sel_word,
  input logic        sel_is_high
);
  // R4: without a pin-cause write no pin cause bit drops
  assert_pin_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_cause_we |=> (($past(pin_cause) & ~pin_cause) == 32'h0));

  // R4: bits written as zero are clear after the write
  assert_pin_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_cause_we |=> ((pin_cause & ~$past(bus_wdata)) == 32'h0));

  // R8: a presented vector always comes with the CPU line
  assert_vec_implies_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> irq_out);

  // R9: group field never holds the unused code
  assert_vec_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_id[6:5] != 2'b11));

  // R10: a low-group vector only when the select view shows the low half
  assert_low_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_id[6:5] == 2'b00) |-> !sel_is_high);

  // R7: the low half is shown only when it has a pending bit
  assert_select_low_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_is_high |-> (sel_word != 32'h0));

  // R6: with the pin mask empty no summary bit is set
  assert_summary_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mask == 32'h0) |-> (hi_cause_view[27:24] == 4'h0));
endmodule

bind cascaded_irq_ctrl icc_checker u_icc_checker (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .vec_valid(vec_valid),
  .vec_id(vec_id), .pin_cause_we(pin_cause_we), .bus_wdata(bus_wdata),
  .pin_cause(pin_cause), .pin_mask(pin_mask), .hi_cause_view(hi_cause_view),
  .sel_word(sel_word), .sel_is_high(sel_is_high)
);

// File: tb/cascaded_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cascaded_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, src_pin = '0;
  logic        bus_win = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, vec_valid;
  logic [6:0]  vec_id;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cascaded_irq_ctrl u_cascaded_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi), .src_pin(src_pin),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .vec_valid(vec_valid), .vec_id(vec_id)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic win, input logic [7:0] a, output logic [31:0] d);
    bus_win = win; bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wr(input logic win, input logic [7:0] a, input logic [31:0] d);
    bus_win = win; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  // bench-side model of the vector: low, then pins via summary, then high
  function automatic logic [7:0] hi_msb(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 8'(i);
    return 8'd0;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "irq", {31'd0, irq_out}, 32'd0);
    chk("R1", "vec_valid", {31'd0, vec_valid}, 32'd0);
    rd(0, 8'h04, d); chk("R1", "cause lo", d, 32'h0);
    rd(0, 8'h14, d); chk("R1", "mask lo", d, 32'h0);
    rd(0, 8'h1C, d); chk("R1", "mask hi", d, 32'h0);
    rd(1, 8'h08, d); chk("R1", "pin cause", d, 32'h0);
    rd(1, 8'h0C, d); chk("R1", "pin mask", d, 32'h0);
  endtask

  task automatic t_main_track;
    logic [31:0] d;
    src_lo = 32'h8000_0011; src_hi = 32'hFFFF_FFFF;
    tick();
    rd(0, 8'h04, d); chk("R2", "cause lo follows", d, 32'h8000_0011);
    rd(0, 8'h0C, d); chk("R2", "cause hi hole", d, 32'hF0FF_FFFF);
    src_lo = '0; src_hi = '0;
    tick();
    rd(0, 8'h04, d); chk("R2", "cause lo drops", d, 32'h0);
  endtask

  task automatic t_main_clear;
    logic [31:0] d;
    src_lo = 32'h0000_00F0; src_hi = 32'h0000_0300;
    tick();
    wr(0, 8'h04, 32'h0000_00C0);
    rd(0, 8'h04, d); chk("R3", "lo partial clear", d, 32'h0000_00C0);
    tick();
    rd(0, 8'h04, d); chk("R3", "lo re-set", d, 32'h0000_00F0);
    wr(0, 8'h0C, 32'h0);
    rd(0, 8'h0C, d); chk("R3", "hi cleared", d, 32'h0);
    tick();
    rd(0, 8'h0C, d); chk("R3", "hi re-set", d, 32'h0000_0300);
    src_lo = '0; src_hi = '0; tick();
  endtask

  task automatic t_pin;
    logic [31:0] d;
    src_pin = 32'h0000_0101; tick(); src_pin = '0; tick();
    rd(1, 8'h08, d); chk("R4", "pin sticky", d, 32'h0000_0101);
    wr(1, 8'h08, 32'hFFFF_FEFF);
    rd(1, 8'h08, d); chk("R4", "pin write-0 clears", d, 32'h0000_0001);
    src_pin = 32'h0000_0008;
    wr(1, 8'h08, 32'h0);
    rd(1, 8'h08, d); chk("R4", "no capture on write", d, 32'h0);
    tick();
    rd(1, 8'h08, d); chk("R4", "capture after write", d, 32'h0000_0008);
    src_pin = '0;
    wr(1, 8'h08, 32'h0);
    rd(1, 8'h08, d); chk("R4", "pin all clear", d, 32'h0);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    wr(0, 8'h14, 32'hAAAA_5555);
    wr(0, 8'h1C, 32'h1234_5678);
    wr(1, 8'h0C, 32'h0F0F_0F0F);
    rd(0, 8'h14, d); chk("R5", "mask lo", d, 32'hAAAA_5555);
    rd(0, 8'h1C, d); chk("R5", "mask hi", d, 32'h1234_5678);
    rd(1, 8'h0C, d); chk("R5", "pin mask", d, 32'h0F0F_0F0F);
    wr(0, 8'h14, 32'h0); wr(0, 8'h1C, 32'h0); wr(1, 8'h0C, 32'h0);
    rd(0, 8'h14, d); chk("R5", "mask lo zeroed", d, 32'h0);
  endtask

  task automatic t_summary;
    logic [31:0] d;
    src_pin = 32'h0002_0008; tick(); src_pin = '0;
    wr(1, 8'h0C, 32'h0000_0008);
    rd(0, 8'h0C, d); chk("R6", "summary one slice", d, 32'h0100_0000);
    wr(1, 8'h0C, 32'hFFFF_FFFF);
    rd(0, 8'h0C, d); chk("R6", "summary two slices", d, 32'h0500_0000);
    chk("R8", "summary with hi mask 0", {31'd0, irq_out}, 32'd0);
    wr(1, 8'h08, 32'h0); wr(1, 8'h0C, 32'h0);
    rd(0, 8'h0C, d); chk("R6", "summary cleared", d, 32'h0);
  endtask

  task automatic t_select_vec;
    logic [31:0] d;
    src_lo = 32'h0000_0010; tick();
    chk("R8", "masked low no irq", {31'd0, irq_out}, 32'd0);
    wr(0, 8'h14, 32'h0000_0010);
    chk("R8", "unmasked low irq", {31'd0, irq_out}, 32'd1);
    rd(0, 8'h24, d); chk("R7", "select low", d, 32'h0000_0010);
    chk("R9", "vec low", {24'd0, vec_valid, vec_id}, {24'd0, 1'b1, 2'd0, 5'd4});
    src_hi = 32'h0000_0201; wr(0, 8'h1C, 32'h0000_0200);
    rd(0, 8'h24, d); chk("R10", "low has priority", d, 32'h0000_0010);
    src_lo = '0; tick();
    rd(0, 8'h24, d); chk("R7", "select high flag", d, 32'h4000_0200);
    chk("R9", "vec high", {24'd0, vec_valid, vec_id},
        {24'd0, 1'b1, 2'd1, hi_msb(32'h0000_0200)[4:0]});
    src_pin = 32'h4000_0020; tick(); src_pin = '0;
    wr(1, 8'h0C, 32'hFFFF_FFFF);
    wr(0, 8'h1C, 32'h0F00_0200);
    rd(0, 8'h24, d); chk("R7", "select with summary", d, 32'h4900_0200);
    chk("R10", "vec pins via summary", {24'd0, vec_valid, vec_id},
        {24'd0, 1'b1, 2'd2, hi_msb(32'h4000_0020)[4:0]});
    wr(0, 8'h1C, 32'h0000_0200);
    chk("R10", "summary masked -> high", {24'd0, vec_valid, vec_id},
        {24'd0, 1'b1, 2'd1, 5'd9});
    src_hi = '0; wr(0, 8'h1C, 32'h0); wr(0, 8'h14, 32'h0);
    wr(1, 8'h08, 32'h0); wr(1, 8'h0C, 32'h0);
    chk("R8", "all idle irq", {31'd0, irq_out}, 32'd0);
    chk("R10", "all idle vec", {31'd0, vec_valid}, 32'd0);
    rd(0, 8'h24, d); chk("R7", "select empty", d, 32'h4000_0000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(0, 8'h14, 32'h0000_0001);
    wr(0, 8'h30, 32'hFFFF_FFFF);
    wr(1, 8'h14, 32'hFFFF_FFFF);
    wr(1, 8'h1C, 32'hFFFF_FFFF);
    rd(0, 8'h14, d); chk("R11", "mask lo untouched", d, 32'h0000_0001);
    rd(0, 8'h1C, d); chk("R11", "mask hi untouched", d, 32'h0);
    rd(1, 8'h0C, d); chk("R11", "pin mask untouched", d, 32'h0);
    rd(0, 8'h30, d); chk("R11", "unmapped main read", d, 32'h0);
    rd(1, 8'h14, d); chk("R11", "unmapped pin read", d, 32'h0);
    wr(0, 8'h14, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_main_track();
    t_main_clear();
    t_pin();
    t_masks();
    t_summary();
    t_select_vec();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule